// File: doc/BRIEF.md
# Two-Slot Clock-Crossing Word Buffer

This block hands one data or control word at a time from a write clock domain to a read clock domain when the two clocks are unrelated. The word is held in one of two storage registers. Each side keeps a single-bit pointer that names a register. Each pointer is carried into the other domain through a chain of flip-flops. The write side compares its own pointer with the synchronized read pointer to decide whether it is full. The read side compares its own pointer with the synchronized write pointer to decide whether it is empty.

After a put, the write pointer has already moved to the other register. When the reader frees the word and ready returns, the next put therefore goes straight into the free slot. The data word itself never passes through a synchronizer. Only one pointer bit changes per transfer, and the register holding the word stays stable for as long as the reader can see it.

Top module: `dual_slot_cdc_fifo`

## Requirements
- R1: After reset, wrdy is 1 and rrdy is 0.
- R2: A put accepted while wrdy is 1 stores wdata and drops wrdy in the next write-clock cycle.
- R3: A put made while wrdy is 0 is ignored: no word is added and the stored word is unchanged.
- R4: A stored word raises rrdy within SYNC_STAGES+1 read-clock cycles, and rdata then equals that word.
- R5: A get accepted while rrdy is 1 drops rrdy in the next read-clock cycle.
- R6: A get made while rrdy is 0 is ignored: rrdy stays 0 and no phantom word is ever delivered.
- R7: After a get, wrdy returns to 1 within SYNC_STAGES+1 write-clock cycles.
- R8: Under random put and get traffic on unrelated clocks, words arrive in order, with none lost and none duplicated.
- R9: While rrdy is 1 and no get is made, rrdy stays 1 and rdata holds its value.
- R10: Each domain has its own active-low reset. While rrst_n is held low, rrdy stays 0 even after puts on the write side. Once rrst_n is released, the pending word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain active-low reset |
| wput | input | 1 | Put request |
| wdata | input | DATA_W | Word to store |
| wrdy | output | 1 | Write side can accept a word |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain active-low reset |
| rget | input | 1 | Get request, frees the presented word |
| rdata | output | DATA_W | Presented word, valid while rrdy is 1 |
| rrdy | output | 1 | A word is presented |

## Verification
wrdy falls one write-clock cycle after an accepted put, and rrdy falls one read-clock cycle after an accepted get. The bench samples both at the next falling edge of the relevant clock.

The rising edges of rrdy and wrdy pass through the synchronizer. For these, the bench counts falling edges of the receiving clock until the flag rises and checks that the count does not exceed SYNC_STAGES+1.

Random traffic is compared word by word against a reference queue at the moment each get is taken.

// File: rtl/dslot_pkg.sv
`timescale 1ns/1ps
package dslot_pkg;
  localparam int unsigned DEF_DATA_W      = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned NUM_SLOTS       = 2;

  typedef logic slot_ptr_t;

  function automatic slot_ptr_t advance_ptr(input slot_ptr_t p, input logic step);
    return step ? ~p : p;
  endfunction
endpackage

// File: rtl/dslot_bit_sync.sv
`timescale 1ns/1ps
module dslot_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb chain_d[g] = d;
      end else begin : g_rest
        always_comb chain_d[g] = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dslot_store.sv
`timescale 1ns/1ps
module dslot_store
  import dslot_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic                           wclk,
  input  logic                           wrst_n,
  input  logic                           wr_en,
  input  slot_ptr_t                      wr_sel,
  input  logic [DATA_W-1:0]              wr_word,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q
);
  logic [NUM_SLOTS-1:0]             slot_en;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_d;

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_comb begin
        slot_en[s] = wr_en && (wr_sel == slot_ptr_t'(s));
        slot_d[s]  = slot_en[s] ? wr_word : slot_q[s];
      end
      always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) slot_q[s] <= '0;
        else         slot_q[s] <= slot_d[s];
      end
    end
  endgenerate

  // r3: at most one slot written per cycle
  p_one_slot_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0(slot_en));
endmodule

// File: rtl/dslot_wr_side.sv
`timescale 1ns/1ps
module dslot_wr_side
  import dslot_pkg::*;
(
  input  logic      wclk,
  input  logic      wrst_n,
  input  logic      wput,
  input  slot_ptr_t rptr_in_w,
  output slot_ptr_t wptr,
  output logic      wr_en,
  output logic      wrdy
);
  slot_ptr_t wptr_q;
  slot_ptr_t wptr_d;
  logic      full;
  logic      accept;

  always_comb begin
    full   = wptr_q ^ rptr_in_w;
    accept = wput && !full;
    wptr_d = advance_ptr(wptr_q, accept);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) wptr_q <= 1'b0;
    else         wptr_q <= wptr_d;
  end

  assign wptr  = wptr_q;
  assign wr_en = accept;
  assign wrdy  = !full;

  p_wrdy_drop_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wput && wrdy) |=> !wrdy);
  p_blocked_put_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wput && !wrdy) |=> $stable(wptr_q));
endmodule

// File: rtl/dslot_rd_side.sv
`timescale 1ns/1ps
module dslot_rd_side
  import dslot_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic                             rclk,
  input  logic                             rrst_n,
  input  logic                             rget,
  input  slot_ptr_t                        wptr_in_r,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q,
  output slot_ptr_t                        rptr,
  output logic                             rrdy,
  output logic [DATA_W-1:0]                rdata
);
  slot_ptr_t rptr_q;
  slot_ptr_t rptr_d;
  logic      empty;
  logic      take;

  always_comb begin
    empty  = !(rptr_q ^ wptr_in_r);
    take   = rget && !empty;
    rptr_d = advance_ptr(rptr_q, take);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rptr_q <= 1'b0;
    else         rptr_q <= rptr_d;
  end

  assign rptr  = rptr_q;
  assign rrdy  = !empty;
  assign rdata = slot_q[rptr_q];

  p_rrdy_drop_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rget && rrdy) |=> !rrdy);
  p_ignored_get_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rget && !rrdy) |=> $stable(rptr_q));
  p_word_held_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rrdy && !rget) |=> (rrdy && $stable(rdata)));
endmodule

// File: rtl/dual_slot_cdc_fifo.sv
`timescale 1ns/1ps
module dual_slot_cdc_fifo
  import dslot_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wput,
  input  logic [DATA_W-1:0] wdata,
  output logic              wrdy,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rget,
  output logic [DATA_W-1:0] rdata,
  output logic              rrdy
);
  slot_ptr_t                        wptr;
  slot_ptr_t                        rptr;
  slot_ptr_t                        wptr_in_r;
  slot_ptr_t                        rptr_in_w;
  logic                             wr_en;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;

  dslot_wr_side u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wput(wput), .rptr_in_w(rptr_in_w),
    .wptr(wptr), .wr_en(wr_en), .wrdy(wrdy)
  );

  dslot_store #(.DATA_W(DATA_W)) u_store (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_sel(wptr),
    .wr_word(wdata), .slot_q(slot_q)
  );

  dslot_bit_sync #(.STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wptr), .q(wptr_in_r)
  );

  dslot_bit_sync #(.STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rptr), .q(rptr_in_w)
  );

  dslot_rd_side #(.DATA_W(DATA_W)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rget(rget), .wptr_in_r(wptr_in_r),
    .slot_q(slot_q), .rptr(rptr), .rrdy(rrdy), .rdata(rdata)
  );
endmodule

// File: tb/sim_dual_slot_cdc_fifo.sv
`timescale 1ns/1ps
module sim_dual_slot_cdc_fifo;
  localparam int DW     = 16;
  localparam int SYNC   = 2;
  localparam int NWORDS = 400;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n, rrst_n, wput, rget;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic wrdy, rrdy;
  int checks = 0, fails = 0;
  logic [DW-1:0] refq[$];

  dual_slot_cdc_fifo #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wput(wput), .wdata(wdata), .wrdy(wrdy),
    .rclk(rclk), .rrst_n(rrst_n), .rget(rget), .rdata(rdata), .rrdy(rrdy)
  );

  always #2.5 wclk = ~wclk;
  initial begin
    #1.3;
    forever #3.65 rclk = ~rclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd9137));
    wput = 0; rget = 0; wdata = '0; wrst_n = 0; rrst_n = 0;
    repeat (4) @(posedge wclk);
    @(negedge wclk) wrst_n = 1;
    @(negedge rclk) rrst_n = 1;
    @(negedge wclk);
    chk(wrdy == 1'b1, "R1 wrdy", int'(wrdy), 1);
    chk(rrdy == 1'b0, "R1 rrdy", int'(rrdy), 0);

    // R2: accepted put drops wrdy
    wdata = 16'hA5A5; wput = 1;
    @(negedge wclk) wput = 0;
    chk(wrdy == 1'b0, "R2 wrdy after put", int'(wrdy), 0);

    // R4: latency and presented word
    n = 0;
    @(negedge rclk);
    while (!rrdy && n < 10) begin n++; @(negedge rclk); end
    chk(n <= SYNC + 1, "R4 rrdy latency", n, SYNC + 1);
    chk(rdata == 16'hA5A5, "R4 rdata", int'(rdata), 16'hA5A5);

    // R3: blocked puts
    @(negedge wclk) begin wdata = 16'h5A5A; wput = 1; end
    for (int i = 0; i < 6; i++) begin
      @(negedge wclk);
      chk(wrdy == 1'b0, "R3 wrdy held low", int'(wrdy), 0);
    end
    wput = 0;

    // R9: word held without get
    for (int i = 0; i < 5; i++) begin
      @(negedge rclk);
      chk(rrdy == 1'b1 && rdata == 16'hA5A5, "R9 word held", int'(rdata), 16'hA5A5);
    end

    // R5: get drops rrdy
    rget = 1;
    @(negedge rclk) rget = 0;
    chk(rrdy == 1'b0, "R5 rrdy after get", int'(rrdy), 0);

    // R7: wrdy returns
    n = 0;
    @(negedge wclk);
    while (!wrdy && n < 10) begin n++; @(negedge wclk); end
    chk(n <= SYNC + 1, "R7 wrdy latency", n, SYNC + 1);

    // R6: ignored gets
    @(negedge rclk) rget = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge rclk);
      chk(rrdy == 1'b0, "R6 rrdy stays low", int'(rrdy), 0);
    end
    rget = 0;

    // R3/R6: next word is the new one, no leftover or phantom
    @(negedge wclk) begin wdata = 16'h3C3C; wput = 1; end
    @(negedge wclk) wput = 0;
    n = 0;
    @(negedge rclk);
    while (!rrdy && n < 10) begin n++; @(negedge rclk); end
    chk(rdata == 16'h3C3C, "R3 R6 next word", int'(rdata), 16'h3C3C);
    rget = 1;
    @(negedge rclk) rget = 0;

    // R10: read reset held while write side works
    repeat (4) @(negedge wclk);
    wrst_n = 0; rrst_n = 0;
    repeat (3) @(negedge wclk);
    wrst_n = 1;
    @(negedge wclk) begin wdata = 16'h7E7E; wput = 1; end
    @(negedge wclk) wput = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge rclk);
      chk(rrdy == 1'b0, "R10 rrdy in read reset", int'(rrdy), 0);
    end
    rrst_n = 1;
    n = 0;
    @(negedge rclk);
    while (!rrdy && n < 10) begin n++; @(negedge rclk); end
    chk(rrdy == 1'b1 && rdata == 16'h7E7E, "R10 word after release", int'(rdata), 16'h7E7E);
    rget = 1;
    @(negedge rclk) rget = 0;
    repeat (6) @(negedge wclk);

    // R8: random traffic
    fork
      begin : writer
        int sent = 0;
        while (sent < NWORDS) begin
          @(negedge wclk);
          wput  = ($urandom % 3) != 0;
          wdata = DW'($urandom);
          if (wput && wrdy) begin refq.push_back(wdata); sent++; end
        end
        @(negedge wclk) wput = 0;
      end
      begin : reader
        int got = 0;
        logic [DW-1:0] exp;
        while (got < NWORDS) begin
          @(negedge rclk);
          rget = ($urandom % 2) != 0;
          if (rget && rrdy) begin
            if (refq.size() == 0) begin
              chk(1'b0, "R8 phantom word", int'(rdata), 0);
            end else begin
              exp = refq.pop_front();
              chk(rdata == exp, "R8 order", int'(rdata), int'(exp));
            end
            got++;
          end
        end
        @(negedge rclk) rget = 0;
      end
    join
    repeat (10) @(negedge rclk);
    chk(rrdy == 1'b0, "R8 drained rrdy", int'(rrdy), 0);
    chk(refq.size() == 0, "R8 no lost words", refq.size(), 0);
    @(negedge wclk);
    chk(wrdy == 1'b1, "R8 drained wrdy", int'(wrdy), 1);
    finish_run();
  end
endmodule